// File: doc/BRIEF.md
# DDR Read Strobe Gate

This block cleans up the read data strobe returned by a DDR memory so that only the pulses belonging to a read reach the capture logic. The strobe idles at high impedance and picks up reflections when the memory starts and stops driving it, both before the first pulse and after the last one. The block opens a gate (the mask) around the real pulses and closes it again before the trailing noise arrives. The strobe leaving the block is the raw strobe ANDed with the mask.

No calibration is involved. In the controller clock domain, the block registers the DFI read-data-enable pulse. It counts the cycles that the registered enable stays high, and that count is the number of strobe falling edges the read will bring. A second counter, clocked by the falling edges of the gated strobe, counts the edges that actually arrive. The mask opens a programmable number of fast-clock steps after the registered enable rises. After the enable has fallen, the mask drops as soon as the two counts agree. A fast oversampling clock `os_clk` runs the tap delay and the mask register. The tap value is chosen once for the board's round-trip delay, and the mask should open about halfway through the preamble.

Top module: `rd_strobe_gate`

## Requirements
- R1: While `rst` is high and after it is released, `mask` is low and `strobe_out` stays low whatever `rd_strobe` does.
- R2: The expected edge count equals the number of `dfi_clk` cycles in which the registered `dfi_rddata_en` is high. A read whose enable lasts N cycles lets exactly N strobe pulses through, for N from 1 to 15 with the default count width of 4 bits.
- R3: The received edge count advances on each falling edge of the gated strobe, so pulses outside the mask are not counted.
- R4: `mask` rises on the (`tap_sel`+1)-th `os_clk` rising edge after the first `os_clk` edge that samples the registered enable high. A `tap_sel` of 0 adds no delay steps.
- R5: While the registered enable, stretched by one `os_clk` cycle, is high, `mask` cannot fall, even when the two counts are equal.
- R6: Once the enable is no longer selected, `mask` falls no later than the second `os_clk` rising edge after the last expected strobe falling edge, so a postamble glitch half a `dfi_clk` period later is removed.
- R7: When `mask` falls, both counts return to zero. `mask` stays low, and stray strobe pulses give no output, until the next rising edge of the registered enable. Back-to-back reads each pass their own pulse count.
- R8: `strobe_out` equals `rd_strobe` AND `mask` at all times.
- R9: A preamble glitch that ends before `mask` opens does not reach `strobe_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dfi_clk | input | 1 | Controller clock; the enable register and the expected counter run on its rising edge |
| os_clk | input | 1 | Fast oversampling clock for the tap delay, the count compare and the mask register |
| rst | input | 1 | Synchronous active-high reset |
| dfi_rddata_en | input | 1 | DFI read-data-enable, high for one cycle per expected strobe pulse |
| rd_strobe | input | 1 | Raw read strobe from the pad |
| tap_sel | input | 6 | Mask opening delay in `os_clk` steps (0 to 63) |
| mask | output | 1 | Registered strobe qualification window |
| strobe_out | output | 1 | Raw strobe ANDed with the mask |

## Verification
The bench runs reads of 1, 4, 7, 10 and 15 pulses back to back, with preamble and postamble glitches injected. If the expected counter were off by one cycle, the pulse count would be wrong or the trailing glitch would get through. The bench times the mask's rising edge for several tap values, including zero, so a delay line that is off by one stage is caught. It samples the mask in the middle of a read, where the two counts already match, to catch a selector that listens to the compare too early. It also samples just before and just after the last falling edge, to catch a close that comes early or late. A stray pulse sent after a read, followed by a further read, shows whether the counters were really cleared and held.

// File: rtl/rsg_pkg.sv
`timescale 1ns/1ps
package rsg_pkg;
  // default width of the tap setting; the delay line has 2**width stages
  localparam int DEF_TAP_W = 6;
  // default width of both edge counters
  localparam int DEF_CNT_W = 4;
endpackage

// File: rtl/smk_expect_cnt.sv
`timescale 1ns/1ps
module smk_expect_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             dfi_clk,
  input  logic             rst,
  input  logic             rddata_en,
  input  logic             mask_in,
  output logic             en_q,
  output logic [CNT_W-1:0] exp_cnt
);
  logic idle_clr;

  // counts are dropped only while no read is open and the window is shut
  assign idle_clr = ~en_q & ~mask_in;

  always_ff @(posedge dfi_clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      exp_cnt <= '0;
    end else begin
      en_q <= rddata_en;
      if (idle_clr)
        exp_cnt <= '0;
      else if (en_q)
        exp_cnt <= exp_cnt + 1'b1;
    end
  end

  // R2: outside the enable the expected count never advances
  a_r2_hold_outside_enable: assert property (@(posedge dfi_clk) disable iff (rst)
    (!en_q) |=> (exp_cnt == '0 || $stable(exp_cnt)));

  // R7: every read starts from a cleared count
  a_r7_fresh_count: assert property (@(posedge dfi_clk) disable iff (rst)
    $rose(en_q) |-> (exp_cnt == '0));
endmodule

// File: rtl/smk_delay_line.sv
`timescale 1ns/1ps
module smk_delay_line #(
  parameter int TAP_W = 6
) (
  input  logic             os_clk,
  input  logic             rst,
  input  logic             en_in,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             tap_out,
  output logic             sel_hold
);
  localparam int DEPTH = 1 << TAP_W;

  logic [DEPTH-1:0] stage;

  // stage 0 is the first fast-clock sample of the registered enable
  always_ff @(posedge os_clk) begin
    if (rst) stage[0] <= 1'b0;
    else     stage[0] <= en_in;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge os_clk) begin
      if (rst) stage[i] <= 1'b0;
      else     stage[i] <= stage[i-1];
    end
  end

  assign tap_out  = stage[tap_sel];
  // selector input: enable sample stretched one cycle on its falling side
  assign sel_hold = stage[0] | stage[1];
endmodule

// File: rtl/smk_edge_cnt.sv
`timescale 1ns/1ps
module smk_edge_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             os_clk,
  input  logic             rst,
  input  logic             qstrobe,
  input  logic             clr,
  input  logic [CNT_W-1:0] exp_cnt,
  output logic             mismatch_q
);
  logic [CNT_W-1:0] got_cnt;

  // counts falling edges of the gated strobe; cleared at once between reads
  always_ff @(negedge qstrobe or posedge clr) begin
    if (clr) got_cnt <= '0;
    else     got_cnt <= got_cnt + 1'b1;
  end

  // compare result brought into the fast domain before the selector uses it
  always_ff @(posedge os_clk) begin
    if (rst) mismatch_q <= 1'b0;
    else     mismatch_q <= (got_cnt != exp_cnt);
  end
endmodule

// File: rtl/rd_strobe_gate.sv
`timescale 1ns/1ps
module rd_strobe_gate
  import rsg_pkg::*;
#(
  parameter int TAP_W = DEF_TAP_W,
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             dfi_clk,
  input  logic             os_clk,
  input  logic             rst,
  input  logic             dfi_rddata_en,
  input  logic             rd_strobe,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             mask,
  output logic             strobe_out
);
  logic             en_q;
  logic [CNT_W-1:0] exp_cnt;
  logic             tap_out;
  logic             sel_hold;
  logic             mismatch_q;
  logic             cnt_clr;

  smk_expect_cnt #(.CNT_W(CNT_W)) u_expect (
    .dfi_clk   (dfi_clk),
    .rst       (rst),
    .rddata_en (dfi_rddata_en),
    .mask_in   (mask),
    .en_q      (en_q),
    .exp_cnt   (exp_cnt)
  );

  smk_delay_line #(.TAP_W(TAP_W)) u_delay (
    .os_clk   (os_clk),
    .rst      (rst),
    .en_in    (en_q),
    .tap_sel  (tap_sel),
    .tap_out  (tap_out),
    .sel_hold (sel_hold)
  );

  assign cnt_clr = rst | (~en_q & ~mask);

  smk_edge_cnt #(.CNT_W(CNT_W)) u_edges (
    .os_clk     (os_clk),
    .rst        (rst),
    .qstrobe    (strobe_out),
    .clr        (cnt_clr),
    .exp_cnt    (exp_cnt),
    .mismatch_q (mismatch_q)
  );

  // selector: while the enable is chosen the window may only open;
  // afterwards it may only close, and does so once the counts agree
  always_ff @(posedge os_clk) begin
    if (rst)
      mask <= 1'b0;
    else if (sel_hold)
      mask <= tap_out | mask;
    else
      mask <= mask & mismatch_q;
  end

  assign strobe_out = rd_strobe & mask;

  // R4: the window opens only behind the selected delay stage
  a_r4_open_on_tap: assert property (@(posedge os_clk) disable iff (rst)
    $rose(mask) |-> $past(tap_out));

  // R5: no close while the enable is still selected
  a_r5_no_early_close: assert property (@(posedge os_clk) disable iff (rst)
    $fell(mask) |-> !$past(sel_hold));

  // R6: a close always follows a count match
  a_r6_close_on_match: assert property (@(posedge os_clk) disable iff (rst)
    $fell(mask) |-> !$past(mismatch_q));

  // R7: once shut with no enable, the window stays shut
  a_r7_stay_shut: assert property (@(posedge os_clk) disable iff (rst)
    (!mask && !sel_hold) |=> !mask);
endmodule

// File: tb/rd_strobe_gate_tb.sv
`timescale 1ns/1ps
module rd_strobe_gate_tb_top;
  localparam real DFI_PERIOD = 16.0;
  localparam real OS_PERIOD  = 2.0;
  // os_clk rises at odd ns, dfi_clk rises at 16k+1.5: first os edge 1.5 ns later
  localparam real FIRST_OS   = 1.5;
  localparam real WD_NS      = 100000.0;

  localparam int NV = 6;
  localparam int V_EDGES [NV] = '{4, 10, 1, 7, 15, 4};
  localparam int V_TAP   [NV] = '{3, 2, 2, 3, 0, 1};
  localparam bit V_PRE   [NV] = '{1, 1, 1, 1, 0, 1};

  logic       dfi_clk = 1'b0;
  logic       os_clk = 1'b0;
  logic       rst = 1'b1;
  logic       dfi_rddata_en = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [5:0] tap_sel = '0;
  logic       mask;
  logic       strobe_out;

  int  total = 0;
  int  bad = 0;
  int  pulse_cnt = 0;
  real t_rise = -1.0;
  real t_e1 = 0.0;

  rd_strobe_gate dut_i (
    .dfi_clk       (dfi_clk),
    .os_clk        (os_clk),
    .rst           (rst),
    .dfi_rddata_en (dfi_rddata_en),
    .rd_strobe     (rd_strobe),
    .tap_sel       (tap_sel),
    .mask          (mask),
    .strobe_out    (strobe_out)
  );

  initial forever #(OS_PERIOD/2) os_clk = ~os_clk;
  initial begin
    #1.5;
    forever begin
      dfi_clk = 1'b1; #(DFI_PERIOD/2);
      dfi_clk = 1'b0; #(DFI_PERIOD/2);
    end
  end

  always @(posedge strobe_out) pulse_cnt++;
  always @(posedge mask) t_rise = $realtime;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_read(input int n, input int tap, input bit pre_gl);
    tap_sel   = 6'(tap);
    pulse_cnt = 0;
    t_rise    = -1.0;
    @(posedge dfi_clk); #1 dfi_rddata_en = 1'b1;
    @(posedge dfi_clk); t_e1 = $realtime;
    fork
      begin
        repeat (n-1) @(posedge dfi_clk);
        #1 dfi_rddata_en = 1'b0;
      end
      begin
        #4;
        if (pre_gl) rd_strobe = 1'b1;
        #0.5 rd_strobe = 1'b0;
        #5.5;
        for (int k = 0; k < n; k++) begin
          rd_strobe = 1'b1; #8;
          rd_strobe = 1'b0; #8;
        end
        rd_strobe = 1'b1; #0.5;
        rd_strobe = 1'b0; #2;
      end
      begin
        if (n >= 2) begin
          #30;
          chk(mask == 1'b1, "R5 mask open mid-read", int'(mask), 1);
          chk(strobe_out == 1'b1, "R8 strobe passes while open", int'(strobe_out), 1);
          #6;
          chk(strobe_out == 1'b0, "R8 strobe low passes low", int'(strobe_out), 0);
          #(16.0*n - 34.5);
        end else begin
          #(16.0*n + 1.5);
        end
        chk(mask == 1'b1, "R5 mask open before last edge", int'(mask), 1);
        #5.5;
        chk(mask == 1'b0, "R6 mask closed after last edge", int'(mask), 0);
      end
    join
    chk(pulse_cnt == n, "R2 R3 R9 pulse count", pulse_cnt, n);
    chk((t_rise - t_e1) > (FIRST_OS + OS_PERIOD*(tap+1)) - 0.01 &&
        (t_rise - t_e1) < (FIRST_OS + OS_PERIOD*(tap+1)) + 0.01,
        "R4 mask open time x10ps", int'((t_rise - t_e1)*100.0),
        int'((FIRST_OS + OS_PERIOD*(tap+1))*100.0));
  endtask

  initial begin
    #WD_NS;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset holds the window shut
    repeat (3) @(posedge dfi_clk);
    #3 rd_strobe = 1'b1;
    #2;
    chk(mask == 1'b0, "R1 mask in reset", int'(mask), 0);
    chk(strobe_out == 1'b0, "R1 output in reset", int'(strobe_out), 0);
    rd_strobe = 1'b0;
    @(posedge dfi_clk); #1 rst = 1'b0;
    repeat (2) @(posedge dfi_clk);
    #2;
    chk(mask == 1'b0, "R1 mask after reset", int'(mask), 0);

    // back-to-back reads from the table (R2 R3 R4 R5 R6 R7 R9)
    for (int v = 0; v < NV; v++)
      run_read(V_EDGES[v], V_TAP[v], V_PRE[v]);

    // R7: stray pulses after a read are blocked, then a read still counts right
    repeat (3) @(posedge dfi_clk);
    pulse_cnt = 0;
    for (int k = 0; k < 3; k++) begin
      #3 rd_strobe = 1'b1;
      #3 rd_strobe = 1'b0;
    end
    #2;
    chk(pulse_cnt == 0, "R7 stray pulses blocked", pulse_cnt, 0);
    chk(mask == 1'b0, "R7 mask stays shut", int'(mask), 0);
    run_read(4, 2, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule